// File: doc/BRIEF.md
# Framed SPI Parameter Receiver

This block is a serial receiver for a lighting controller. A host drives it as a Mode 0 SPI target: the clock idles low, data is sampled on the rising clock edge, and bytes arrive most significant bit first. The block brings the serial clock, data line and active-low select into the system clock domain. It assembles bytes and reports each byte with a one-cycle strobe.

A packet is one start byte of value 0x55 followed by exactly seven payload bytes. The seven payload bytes fill seven 8-bit parameter outputs. In arrival order these are intensity, colour index, red, green, blue, white and mode. The start byte is not stored. Every byte seen before a start byte is thrown away. The payload is collected in a staging store. All seven outputs load together in the cycle in which a one-cycle update pulse is raised, so downstream colour logic never reads a mix of old and new fields.

Raising the select line ends a transfer and abandons any packet that is not finished. The system clock must run at least four times faster than the serial clock.

Top module: `spi_pkt_rx`

## Requirements
- R1: After reset, intensity, colour index, red, green, blue and white read 0x00, mode reads 0x21, and update and byte-valid are low.
- R2: While select is low, each group of eight rising serial-clock edges yields one byte on byte_data_o, MSB first. byte_valid_o is high for exactly one system clock per byte.
- R3: While waiting for a start byte, any byte other than 0x55 is discarded and changes no output.
- R4: The seven bytes after 0x55 are mapped by position: 1st intensity, 2nd colour index, 3rd red, 4th green, 5th blue, 6th white, 7th mode.
- R5: All seven outputs change only in the cycle in which update_o is high. update_o is high for exactly one cycle per completed packet.
- R6: If select goes high before the seventh payload byte, the partial packet is discarded: no update pulse and no output change.
- R7: Raising select also clears the bit count, so a byte cut short does not shift the alignment of the next transfer.
- R8: After a packet completes, the receiver waits for a new 0x55. Later bytes in the same transfer do not change the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Active-low select |
| byte_valid_o | output | 1 | One-cycle strobe per received byte |
| byte_data_o | output | 8 | Last received byte |
| update_o | output | 1 | One-cycle pulse on packet commit |
| intensity_o | output | 8 | Intensity parameter |
| color_idx_o | output | 8 | Colour index parameter |
| red_o | output | 8 | Red parameter |
| green_o | output | 8 | Green parameter |
| blue_o | output | 8 | Blue parameter |
| white_o | output | 8 | White parameter |
| mode_o | output | 8 | Mode parameter |

## Verification
A rising serial-clock edge at the pins reaches the shifter on the third system clock edge, because it passes two synchroniser flops and the edge-detect register. The byte strobe is registered on that same edge, and the commit with its update pulse follows one edge later. The bench therefore ends every transfer with at least 20 idle system clocks before it compares the outputs. Strobes and update pulses are counted on every clock edge by monitors, so a pulse that comes early or late, or is doubled or missing, changes a count rather than depending on when a sample is taken. All inputs are driven on the falling system clock edge and outputs are read there too.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned NUM_FIELDS = 7;
  localparam int unsigned IDX_W      = $clog2(NUM_FIELDS);
  localparam int unsigned BANK_W     = BYTE_W * NUM_FIELDS;

  // payload position of each field, arrival order
  localparam int unsigned F_INTENSITY = 0;
  localparam int unsigned F_COLOR_IDX = 1;
  localparam int unsigned F_RED       = 2;
  localparam int unsigned F_GREEN     = 3;
  localparam int unsigned F_BLUE      = 4;
  localparam int unsigned F_WHITE     = 5;
  localparam int unsigned F_MODE      = 6;

  typedef enum logic [0:0] {
    ST_HUNT = 1'b0,
    ST_LOAD = 1'b1
  } pkt_state_e;
endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned         WIDTH   = 3,
  parameter int unsigned         STAGES  = 2,
  parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              cs_n_s,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic              sck_prev_q;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              valid_q, valid_d;
  logic [BYTE_W-1:0] byte_q;
  logic              sck_rise;
  logic [BYTE_W-1:0] shift_next;

  assign sck_rise   = sck_s & ~sck_prev_q & ~cs_n_s;
  assign shift_next = {shift_q[BYTE_W-2:0], mosi_s};

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    valid_d = 1'b0;
    if (cs_n_s) begin
      cnt_d = '0;
    end else if (sck_rise) begin
      shift_d = shift_next;
      if (cnt_q == CNT_LAST) begin
        cnt_d   = '0;
        valid_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      shift_q    <= '0;
      cnt_q      <= '0;
      valid_q    <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
      shift_q    <= shift_d;
      cnt_q      <= cnt_d;
      valid_q    <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (valid_d) byte_q <= shift_next;
  end

  assign byte_valid_o = valid_q;
  assign byte_o       = byte_q;
endmodule

// File: rtl/spi_pkt_assembler.sv
module spi_pkt_assembler
  import spi_pkt_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'h55,
  parameter logic [BYTE_W-1:0] MODE_RST  = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              update_o,
  output logic [BANK_W-1:0] bank_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_FIELDS - 1);

  pkt_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              stage_we;
  logic              commit;
  logic              update_q;
  logic [BYTE_W-1:0] stage_q [NUM_FIELDS-1];
  logic [BYTE_W-1:0] bank_q  [NUM_FIELDS];

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    stage_we = 1'b0;
    commit   = 1'b0;
    if (cs_n_s) begin
      state_d = ST_HUNT;
      idx_d   = '0;
    end else if (byte_valid_i) begin
      case (state_q)
        ST_HUNT: begin
          if (byte_i == SYNC_BYTE) begin
            state_d = ST_LOAD;
            idx_d   = '0;
          end
        end
        ST_LOAD: begin
          if (idx_q == IDX_LAST) begin
            commit  = 1'b1;
            state_d = ST_HUNT;
            idx_d   = '0;
          end else begin
            stage_we = 1'b1;
            idx_d    = idx_q + 1'b1;
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HUNT;
      idx_q    <= '0;
      update_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      update_q <= commit;
    end
  end

  generate
    for (genvar i = 0; i < NUM_FIELDS - 1; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else if (stage_we && (idx_q == IDX_W'(i))) stage_q[i] <= byte_i;
      end
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_bank
      localparam logic [BYTE_W-1:0] RV = (i == F_MODE) ? MODE_RST : '0;
      if (i == NUM_FIELDS - 1) begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)      bank_q[i] <= RV;
          else if (commit) bank_q[i] <= byte_i;
        end
      end else begin : g_staged
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)      bank_q[i] <= RV;
          else if (commit) bank_q[i] <= stage_q[i];
        end
      end
      assign bank_o[i*BYTE_W +: BYTE_W] = bank_q[i];
    end
  endgenerate

  assign update_o = update_q;
endmodule

// File: rtl/spi_pkt_rx.sv
module spi_pkt_rx
  import spi_pkt_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] SYNC_BYTE   = 8'h55,
  parameter logic [BYTE_W-1:0] MODE_RST    = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic              update_o,
  output logic [BYTE_W-1:0] intensity_o,
  output logic [BYTE_W-1:0] color_idx_o,
  output logic [BYTE_W-1:0] red_o,
  output logic [BYTE_W-1:0] green_o,
  output logic [BYTE_W-1:0] blue_o,
  output logic [BYTE_W-1:0] white_o,
  output logic [BYTE_W-1:0] mode_o
);
  logic              rst_n_int;
  logic [2:0]        pins_s;
  logic              sck_s, mosi_s, cs_n_s;
  logic              bv;
  logic [BYTE_W-1:0] bdata;
  logic [BANK_W-1:0] bank;

  spi_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  spi_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n_int),
    .d_i({spi_cs_n, spi_sck, spi_mosi}), .q_o(pins_s)
  );
  assign {cs_n_s, sck_s, mosi_s} = pins_s;

  spi_byte_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n_int), .sck_s(sck_s), .mosi_s(mosi_s),
    .cs_n_s(cs_n_s), .byte_valid_o(bv), .byte_o(bdata)
  );

  spi_pkt_assembler #(.SYNC_BYTE(SYNC_BYTE), .MODE_RST(MODE_RST)) u_asm (
    .clk(clk), .rst_n(rst_n_int), .cs_n_s(cs_n_s),
    .byte_valid_i(bv), .byte_i(bdata), .update_o(update_o), .bank_o(bank)
  );

  assign byte_valid_o = bv;
  assign byte_data_o  = bdata;
  assign intensity_o  = bank[F_INTENSITY*BYTE_W +: BYTE_W];
  assign color_idx_o  = bank[F_COLOR_IDX*BYTE_W +: BYTE_W];
  assign red_o        = bank[F_RED*BYTE_W       +: BYTE_W];
  assign green_o      = bank[F_GREEN*BYTE_W     +: BYTE_W];
  assign blue_o       = bank[F_BLUE*BYTE_W      +: BYTE_W];
  assign white_o      = bank[F_WHITE*BYTE_W     +: BYTE_W];
  assign mode_o       = bank[F_MODE*BYTE_W      +: BYTE_W];
endmodule

// File: rtl/spi_pkt_rx_chk.sv
module spi_pkt_rx_chk #(
  parameter int unsigned BANK_W = 56
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              byte_valid,
  input logic              update,
  input logic [BANK_W-1:0] bank
);
  // R5
  update_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> !update);

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update |-> $stable(bank));

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R6
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
     && $past(spi_cs_n, 4)) |-> (!update && !byte_valid));
endmodule

bind spi_pkt_rx spi_pkt_rx_chk #(.BANK_W(56)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n),
  .byte_valid(byte_valid_o), .update(update_o),
  .bank({intensity_o, color_idx_o, red_o, green_o, blue_o, white_o, mode_o})
);

// File: tb/tb_spi_pkt_rx.sv
module tb_spi_pkt_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic bv, upd;
  logic [7:0] bdata, inten, cidx, red, green, blue, white, mode;

  always #5 clk = ~clk;

  spi_pkt_rx dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_cs_n(cs_n),
    .byte_valid_o(bv), .byte_data_o(bdata), .update_o(upd),
    .intensity_o(inten), .color_idx_o(cidx), .red_o(red), .green_o(green),
    .blue_o(blue), .white_o(white), .mode_o(mode)
  );

  int tests = 0, fails = 0;
  int upd_cnt = 0, bv_cnt = 0;
  logic [7:0] last_byte = 8'h00;
  logic [55:0] exp_bank;
  bit done = 0;

  always @(posedge clk) begin
    if (upd) upd_cnt <= upd_cnt + 1;
    if (bv) begin
      bv_cnt    <= bv_cnt + 1;
      last_byte <= bdata;
    end
  end

  // bit 64: frame should commit; bits 63:0 eight bytes, first byte highest
  localparam logic [64:0] VEC [0:4] = '{
    {1'b1, 64'h55_10_20_30_40_50_60_A4},
    {1'b1, 64'h55_FF_00_80_01_FE_7F_21},
    {1'b0, 64'h54_11_22_33_44_56_66_77},
    {1'b1, 64'h55_00_00_00_00_00_00_00},
    {1'b1, 64'h55_A5_5A_C3_3C_0F_F0_A4}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [55:0] bank_now();
    return {inten, cidx, red, green, blue, white, mode};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = b[i];
      idle(4);
      sck = 1'b1;
      idle(4);
      sck = 1'b0;
    end
  endtask

  task automatic select(); cs_n = 1'b0; idle(4); endtask
  task automatic deselect(); idle(4); cs_n = 1'b1; idle(20); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int u0, b0;
    idle(3);
    rst_n = 1'b1;
    idle(6);
    // R1 reset state
    exp_bank = {48'h0, 8'h21};
    chk(bank_now() == exp_bank, "R1 reset bank", bank_now(), exp_bank);
    chk(!upd && !bv, "R1 strobes low", {upd, bv}, 0);

    // R2 R4 R5 table walk
    foreach (VEC[v]) begin
      u0 = upd_cnt; b0 = bv_cnt;
      select();
      for (int k = 0; k < 8; k++) send_bits(VEC[v][63-8*k -: 8], 8);
      deselect();
      if (VEC[v][64]) exp_bank = VEC[v][55:0];
      chk(bank_now() == exp_bank, "R4 field mapping", bank_now(), exp_bank);
      chk(upd_cnt - u0 == int'(VEC[v][64]), "R5 update count", upd_cnt - u0, VEC[v][64]);
      chk(bv_cnt - b0 == 8, "R2 byte strobes", bv_cnt - b0, 8);
      chk(last_byte == VEC[v][7:0], "R2 MSB-first byte", last_byte, VEC[v][7:0]);
    end

    // R3 junk before start byte
    u0 = upd_cnt;
    select();
    send_bits(8'hAA, 8); send_bits(8'h00, 8); send_bits(8'h55, 8);
    for (int k = 1; k <= 7; k++) send_bits(8'(8'h30 + k), 8);
    deselect();
    exp_bank = 56'h31_32_33_34_35_36_37;
    chk(bank_now() == exp_bank, "R3 junk skipped", bank_now(), exp_bank);
    chk(upd_cnt - u0 == 1, "R3 single update", upd_cnt - u0, 1);

    // R8 trailing bytes after a full packet
    u0 = upd_cnt;
    select();
    send_bits(8'h55, 8);
    for (int k = 1; k <= 7; k++) send_bits(8'(8'h60 + k), 8);
    for (int k = 0; k < 8; k++) send_bits(8'(8'h11 + k), 8);
    deselect();
    exp_bank = 56'h61_62_63_64_65_66_67;
    chk(bank_now() == exp_bank, "R8 trailing ignored", bank_now(), exp_bank);
    chk(upd_cnt - u0 == 1, "R8 one update", upd_cnt - u0, 1);

    // R6 truncated packet
    u0 = upd_cnt;
    select();
    send_bits(8'h55, 8); send_bits(8'hDE, 8); send_bits(8'hAD, 8); send_bits(8'hBE, 8);
    deselect();
    chk(bank_now() == exp_bank, "R6 partial discarded", bank_now(), exp_bank);
    chk(upd_cnt - u0 == 0, "R6 no update", upd_cnt - u0, 0);

    // R7 partial byte then clean packet
    u0 = upd_cnt; b0 = bv_cnt;
    select();
    send_bits(8'hE0, 3);
    deselect();
    chk(bv_cnt - b0 == 0, "R7 no strobe on 3 bits", bv_cnt - b0, 0);
    select();
    send_bits(8'h55, 8);
    for (int k = 1; k <= 7; k++) send_bits(8'(8'h90 + k), 8);
    deselect();
    exp_bank = 56'h91_92_93_94_95_96_97;
    chk(bank_now() == exp_bank, "R7 realigned", bank_now(), exp_bank);
    chk(upd_cnt - u0 == 1, "R7 one update", upd_cnt - u0, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule